// File: doc/BRIEF.md
# Digital PLL Bit-Clock Recovery

This block rebuilds a bit clock from a serial data line. A sampling tick runs at a fixed multiple of the data rate: 32 per bit in NRZI mode and 16 per bit in FM mode. A phase counter advances once per tick. A transition detected on the data line nudges the counter toward the bit boundary by holding it for one tick or by advancing it by two. Two decodes of the counter drive a receive clock, which rises at mid-bit, and a transmit clock, which rises at the bit boundary.

The sampling tick comes from one of two sources. One is a baud-rate tick pulse in the system clock domain. The other is an external clock pin, which is synchronised and reduced to its rising edges. A 3-bit command strobe controls the loop. Commands select the source, select the mode (which also enables the loop) and disable the loop. Software is expected to pick the source first and the mode second, and to change the source only while the loop is disabled.

Top module: `dpll_clk_recovery`

## Requirements
- R1: After reset the loop is disabled, the source is the baud tick and the mode is NRZI. `rx_clk_o` and `tx_clk_o` are low and stay low while ticks arrive.
- R2: Command 3'b111 (NRZI) or 3'b110 (FM) sets the mode, enables the loop and restarts the counter at 0. One cycle later `tx_clk_o` is high and `rx_clk_o` is low.
- R3: Command 3'b001 disables the loop. While it is disabled both clock outputs are low and ticks have no effect.
- R4: Command 3'b100 selects the baud tick and 3'b101 selects the external pin, but only while the loop is disabled. Either command is ignored while the loop is enabled. Codes 3'b000, 3'b010 and 3'b011 are ignored at all times.
- R5: In NRZI mode the counter steps by one per tick, modulo 32. `rx_clk_o` is high for counts 16..31 and `tx_clk_o` for counts 0..15. With no data edges, `rx_clk_o` rises on tick 16 and tick 48 after a restart, and `tx_clk_o` rises on tick 32.
- R6: In FM mode the counter wraps modulo 16. `rx_clk_o` is high for counts 8..15 and `tx_clk_o` for counts 0..7, so `rx_clk_o` rises on tick 8 and `tx_clk_o` on tick 16 after a restart.
- R7: The data input passes through a two-flop synchroniser. A detected transition is held until the next selected tick and applied there, however long the gap is.
- R8: In NRZI mode an edge applied at count c changes the step as follows:
  - c = 0 or c = 16 gives a step of 1.
  - c in 1..15 gives a step of 0 (hold).
  - c in 17..31 gives a step of 2.
- R9: In FM mode an edge applied at a count in 4..11 is ignored (step 1). Counts 1..3 hold, counts 12..15 step by 2, and count 0 steps by 1.
- R10: With the pin source selected, each synchronised rising edge of `ext_clk_i` is one tick and `baud_tick_i` is ignored.
- R11: With a data rate offset from nominal, after lock `rx_clk_o` rises once per bit, within one tick of bit centre. Bit centre is tick 16 of the bit when counted from the tick that carries the transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | Command code |
| baud_tick_i | input | 1 | Baud-rate tick pulse, one cycle wide |
| ext_clk_i | input | 1 | External sampling clock pin, asynchronous |
| rxd_i | input | 1 | Serial receive data, asynchronous |
| rx_clk_o | output | 1 | Recovered receive clock |
| tx_clk_o | output | 1 | Recovered transmit clock |

## Verification
The assertions rely on three properties of the inputs. Commands arrive as single-cycle strobes. Ticks are never coincident with a command. At most one tick is consumed per cycle, so each accepted tick moves the counter by 0, 1 or 2 modulo the active period. The stimulus meets these conditions in two ways. It issues commands only between tick steps. It spaces baud ticks four system cycles apart and external pin edges eight cycles apart, so every synchronised data transition is pending before the tick that is meant to consume it. The random tracking run keeps a transition at least every third bit and lengthens one bit in sixteen by a tick, so the loop always has edges to correct the drift.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam logic [2:0] CMD_OFF      = 3'b001;
  localparam logic [2:0] CMD_SRC_BAUD = 3'b100;
  localparam logic [2:0] CMD_SRC_PIN  = 3'b101;
  localparam logic [2:0] CMD_MODE_FM  = 3'b110;
  localparam logic [2:0] CMD_MODE_NRZ = 3'b111;

  typedef enum logic {SRC_BAUD = 1'b0, SRC_PIN = 1'b1} src_e;
  typedef enum logic {MODE_NRZI = 1'b0, MODE_FM = 1'b1} mode_e;
endpackage

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  output logic       en_o,
  output src_e       src_o,
  output mode_e      mode_o,
  output logic       restart_o
);
  logic  en_q;
  src_e  src_q;
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      src_q  <= SRC_BAUD;
      mode_q <= MODE_NRZI;
    end else if (cmd_valid_i) begin
      case (cmd_i)
        CMD_OFF:      en_q <= 1'b0;
        // source may only move while the counter is frozen
        CMD_SRC_BAUD: if (!en_q) src_q <= SRC_BAUD;
        CMD_SRC_PIN:  if (!en_q) src_q <= SRC_PIN;
        CMD_MODE_FM: begin
          mode_q <= MODE_FM;
          en_q   <= 1'b1;
        end
        CMD_MODE_NRZ: begin
          mode_q <= MODE_NRZI;
          en_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign restart_o = cmd_valid_i && ((cmd_i == CMD_MODE_FM) || (cmd_i == CMD_MODE_NRZ));
  assign en_o      = en_q;
  assign src_o     = src_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/dpll_src_sel.sv
module dpll_src_sel
  import dpll_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic baud_tick_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  // [SYNC_STAGES-1] is the synchronised level, [SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] ext_sh_q;
  logic                 ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh_q <= '0;
    else         ext_sh_q <= {ext_sh_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = ext_sh_q[SYNC_STAGES-1] & ~ext_sh_q[SYNC_STAGES];
  assign tick_o   = (src_i == SRC_PIN) ? ext_rise : baud_tick_i;
endmodule

// File: rtl/dpll_edge_det.sv
module dpll_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic tick_i,
  input  logic rxd_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] rxd_sh_q;
  logic                 edge_now;
  logic                 pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sh_q <= '0;
    else         rxd_sh_q <= {rxd_sh_q[SYNC_STAGES-1:0], rxd_i};
  end

  assign edge_now = rxd_sh_q[SYNC_STAGES-1] ^ rxd_sh_q[SYNC_STAGES];

  // a transition waits here until the next sampling tick consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (!en_i || restart_i)   pend_q <= 1'b0;
    else if (tick_i)               pend_q <= 1'b0;
    else if (edge_now)             pend_q <= 1'b1;
  end

  assign edge_o = pend_q | edge_now;
endmodule

// File: rtl/dpll_phase_ctr.sv
module dpll_phase_ctr
  import dpll_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  mode_e            mode_i,
  input  logic             tick_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PER_N  = 2 ** CNT_W;
  localparam int unsigned HALF_N = PER_N / 2;
  localparam int unsigned HALF_F = PER_N / 4;
  localparam int unsigned WIN_LO = PER_N / 8;
  localparam int unsigned WIN_HI = (3 * PER_N) / 8;

  logic [CNT_W-1:0] cnt_q, half, mask, step, nxt;
  logic             in_win;

  always_comb begin
    half   = (mode_i == MODE_FM) ? CNT_W'(HALF_F) : CNT_W'(HALF_N);
    mask   = (mode_i == MODE_FM) ? CNT_W'(PER_N / 2 - 1) : CNT_W'(PER_N - 1);
    // FM mid-bit window: transitions here carry data, not timing
    in_win = (mode_i == MODE_FM) && (cnt_q >= CNT_W'(WIN_LO)) && (cnt_q < CNT_W'(WIN_HI));
    step   = CNT_W'(1);
    if (edge_i && !in_win) begin
      if (cnt_q == '0 || cnt_q == half) step = CNT_W'(1);
      else if (cnt_q < half)            step = CNT_W'(0);
      else                              step = CNT_W'(2);
    end
    nxt = (cnt_q + step) & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpll_clk_dec.sv
module dpll_clk_dec
  import dpll_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             en_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rx_clk_o,
  output logic             tx_clk_o
);
  localparam int unsigned HALF_N = 2 ** (CNT_W - 1);
  localparam int unsigned HALF_F = 2 ** (CNT_W - 2);

  logic [CNT_W-1:0] half;

  assign half     = (mode_i == MODE_FM) ? CNT_W'(HALF_F) : CNT_W'(HALF_N);
  assign rx_clk_o = en_i && (cnt_i >= half);
  assign tx_clk_o = en_i && (cnt_i < half);
endmodule

// File: rtl/dpll_clk_recovery.sv
module dpll_clk_recovery
  import dpll_pkg::*;
#(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       baud_tick_i,
  input  logic       ext_clk_i,
  input  logic       rxd_i,
  output logic       rx_clk_o,
  output logic       tx_clk_o
);
  logic             en, restart, tick, edge_hit;
  src_e             src;
  mode_e            mode;
  logic [CNT_W-1:0] cnt;

  dpll_ctrl i_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i,
    .en_o(en), .src_o(src), .mode_o(mode), .restart_o(restart)
  );

  dpll_src_sel #(.SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk_i, .rst_ni, .src_i(src), .baud_tick_i, .ext_clk_i, .tick_o(tick)
  );

  dpll_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i, .rst_ni, .en_i(en), .restart_i(restart), .tick_i(tick),
    .rxd_i, .edge_o(edge_hit)
  );

  dpll_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i, .rst_ni, .en_i(en), .restart_i(restart), .mode_i(mode),
    .tick_i(tick), .edge_i(edge_hit), .cnt_o(cnt)
  );

  dpll_clk_dec #(.CNT_W(CNT_W)) i_dec (
    .en_i(en), .mode_i(mode), .cnt_i(cnt), .rx_clk_o, .tx_clk_o
  );
endmodule

// File: rtl/dpll_clk_recovery_chk.sv
module dpll_clk_recovery_chk
  import dpll_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_i,
  input logic             en,
  input logic             src,
  input logic             mode,
  input logic             restart,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             rx_clk_o,
  input logic             tx_clk_o
);
  localparam int unsigned PER_F = 2 ** (CNT_W - 1);

  logic [CNT_W-1:0] cnt_d, delta, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_d <= '0;
    else         cnt_d <= cnt;
  end

  assign mask  = mode ? CNT_W'(PER_F - 1) : '1;
  assign delta = (cnt - cnt_d) & mask;

  p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!rx_clk_o && !tx_clk_o));

  p_src_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && en && (cmd_i[2:1] == 2'b10)) |=> $stable(src));

  p_restart_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (en && cnt == '0 && tx_clk_o && !rx_clk_o));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !tick && !cmd_valid_i) |=> (cnt == cnt_d));

  p_step_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick && !cmd_valid_i) |=> (delta <= CNT_W'(2)));

  p_fm_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && mode) |-> (cnt < CNT_W'(PER_F)));

  p_rx_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_clk_o) |-> $past(tick));
endmodule

bind dpll_clk_recovery dpll_clk_recovery_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .en(en), .src(src), .mode(mode), .restart(restart), .tick(tick), .cnt(cnt),
  .rx_clk_o(rx_clk_o), .tx_clk_o(tx_clk_o)
);

// File: tb/test_dpll_clk_recovery.sv
`timescale 1ns/1ps
module test_dpll_clk_recovery;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic       baud_tick = 1'b0, ext_clk = 1'b0, rxd = 1'b0;
  logic       rx_clk, tx_clk;

  int n_run = 0, n_fail = 0;
  bit prev_rx = 1'b0, prev_tx = 1'b0;

  always #2 clk = ~clk;

  dpll_clk_recovery i_dpll_clk_recovery (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .baud_tick_i(baud_tick), .ext_clk_i(ext_clk), .rxd_i(rxd),
    .rx_clk_o(rx_clk), .tx_clk_o(tx_clk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = 3'b000;
    prev_rx = rx_clk; prev_tx = tx_clk;
  endtask

  // one sampling tick; toggle data with it if asked; outputs sampled afterwards
  task automatic tick_step(input bit tog, input bit pin, output bit r_rx, output bit r_tx);
    @(negedge clk);
    if (tog) rxd = ~rxd;
    if (pin) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end else begin
      baud_tick = 1'b1; @(negedge clk);
      baud_tick = 1'b0; repeat (2) @(negedge clk);
    end
    r_rx = rx_clk && !prev_rx;
    r_tx = tx_clk && !prev_tx;
    prev_rx = rx_clk; prev_tx = tx_clk;
  endtask

  task automatic run_ticks(input int n, input int tog_at, input bit pin,
                           output int rx1, output int rx2, output int tx1);
    bit a, b;
    rx1 = 0; rx2 = 0; tx1 = 0;
    for (int t = 1; t <= n; t++) begin
      tick_step(t == tog_at, pin, a, b);
      if (a) begin
        if (rx1 == 0) rx1 = t;
        else if (rx2 == 0) rx2 = t;
      end
      if (b && tx1 == 0) tx1 = t;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r1, r2, t1, since, rises, len;
    bit tog, a, b;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and disabled loop
    chk(!rx_clk && !tx_clk, "R1 reset outputs", {rx_clk, tx_clk}, 0);
    run_ticks(40, 0, 0, r1, r2, t1);
    chk(r1 == 0 && t1 == 0 && !tx_clk, "R1 disabled ignores ticks", r1 + t1, 0);

    // R2, R5 nominal NRZI
    send_cmd(3'b111);
    chk(tx_clk && !rx_clk, "R2 restart outputs", {rx_clk, tx_clk}, 1);
    run_ticks(50, 0, 0, r1, r2, t1);
    chk(r1 == 16, "R5 first rx rise", r1, 16);
    chk(r2 == 48, "R5 second rx rise", r2, 48);
    chk(t1 == 32, "R5 tx rise", t1, 32);

    // R8 corrections
    send_cmd(3'b111); run_ticks(20, 5, 0, r1, r2, t1);
    chk(r1 == 17, "R8 late edge holds", r1, 17);
    send_cmd(3'b111); run_ticks(50, 20, 0, r1, r2, t1);
    chk(r2 == 47, "R8 early edge advances", r2, 47);
    send_cmd(3'b111); run_ticks(50, 16, 0, r1, r2, t1);
    chk(r2 == 48, "R8 edge at half count", r2, 48);
    send_cmd(3'b111); run_ticks(50, 32, 0, r1, r2, t1);
    chk(r2 == 48, "R8 edge at count zero", r2, 48);

    // R7 pending edge survives a long gap
    send_cmd(3'b111); run_ticks(5, 0, 0, r1, r2, t1);
    @(negedge clk); rxd = ~rxd;
    repeat (20) @(negedge clk);
    run_ticks(20, 0, 0, r1, r2, t1);
    chk(r1 == 12, "R7 held edge applied at next tick", r1 + 5, 17);

    // R4 source command and unused codes ignored while enabled
    send_cmd(3'b111); run_ticks(5, 0, 0, r1, r2, t1);
    send_cmd(3'b101); send_cmd(3'b011); send_cmd(3'b000); send_cmd(3'b010);
    run_ticks(20, 0, 0, r1, r2, t1);
    chk(r1 == 11, "R4 ignored while enabled", r1 + 5, 16);

    // R3 disable
    send_cmd(3'b001);
    chk(!rx_clk && !tx_clk, "R3 disable outputs", {rx_clk, tx_clk}, 0);
    run_ticks(40, 0, 0, r1, r2, t1);
    chk(r1 == 0 && t1 == 0 && !tx_clk, "R3 disabled ignores ticks", r1 + t1, 0);

    // R10 external pin source, accepted while disabled (R4)
    send_cmd(3'b101); send_cmd(3'b111);
    run_ticks(20, 0, 0, r1, r2, t1);
    chk(r1 == 0, "R10 baud ignored on pin source", r1, 0);
    run_ticks(20, 0, 1, r1, r2, t1);
    chk(r1 == 16, "R10 pin edges tick", r1, 16);
    send_cmd(3'b001); send_cmd(3'b100);

    // R6, R9 FM
    send_cmd(3'b110);
    chk(tx_clk && !rx_clk, "R2 FM restart outputs", {rx_clk, tx_clk}, 1);
    run_ticks(30, 0, 0, r1, r2, t1);
    chk(r1 == 8, "R6 FM rx rise", r1, 8);
    chk(t1 == 16, "R6 FM tx rise", t1, 16);
    chk(r2 == 24, "R6 FM period", r2, 24);
    send_cmd(3'b110); run_ticks(12, 2, 0, r1, r2, t1);
    chk(r1 == 9, "R9 FM late edge holds", r1, 9);
    send_cmd(3'b110); run_ticks(12, 6, 0, r1, r2, t1);
    chk(r1 == 8, "R9 FM window edge ignored", r1, 8);
    send_cmd(3'b110); run_ticks(30, 13, 0, r1, r2, t1);
    chk(r2 == 23, "R9 FM early edge advances", r2, 23);

    // R11 tracking with slow data
    send_cmd(3'b111);
    run_ticks(int'($urandom % 32) + 1, 0, 0, r1, r2, t1);
    since = 0;
    for (int bit_i = 0; bit_i < 400; bit_i++) begin
      len   = (bit_i % 16 == 15) ? 33 : 32;
      tog   = (since >= 2) || ($urandom % 4 != 0);
      since = tog ? 0 : since + 1;
      rises = 0;
      for (int pos = 0; pos < len; pos++) begin
        tick_step(pos == 0 && tog, 0, a, b);
        if (a) begin
          rises++;
          if (bit_i >= 64) chk(pos >= 15 && pos <= 17, "R11 rx near bit centre", pos, 16);
        end
      end
      if (bit_i >= 64) chk(rises == 1, "R11 one rx rise per bit", rises, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule